// File: doc/BRIEF.md
# Memory-Mapped UART Controller Core

This block is a serial port that sits behind a simple 32-bit register bus. Software puts characters into a 64-entry transmit queue through one register and takes received characters out of a 64-entry receive queue through another. A control register sets the frame shape (data length, parity and stop bits), enables each direction and each interrupt, and holds the queue resets and the error clear. A status register shows the sticky error flags, the queue full and empty states, and whether a frame is still leaving the shifter.

The 16x oversampling tick (`bitTick`) comes from a separate rate divider. The value software writes to the rate register goes out on `baudCfg` to drive that divider. Two interrupt outputs compare the queue fill levels against programmable thresholds. Their OR is also driven out.

Top module: `uart_mmio_core`

## Requirements
- R1: The control register (byte offset 0x08), threshold register (0x10, bits 15:0 stored, upper bits read 0) and rate register (0x14, all 32 bits, also driven on `baudCfg`) read back what was last written. After reset, control reads 0.
- R2: A frame on `txd` is laid out as follows, and each bit lasts 16 `bitTick` pulses. It opens with a start bit of 0. The data bits follow, LSB first. The count comes from control bits 21:20 (00 gives 8, 01 gives 7, 10 gives 6, 11 gives 5). When control bit 19 is set, a parity bit comes next: bit 18 = 1 selects odd parity, 0 selects even. The frame closes with one stop bit of 1, or two when bits 17:16 = 01. `txd` idles at 1.
- R3: Characters written to offset 0x00 leave the queue only while control bit 12 is 1. While that bit is 0 they wait in the queue and `txd` stays 1.
- R4: While control bit 13 is 1, received frames in the configured format are stored. A read of offset 0x04 returns the oldest character in bits 7:0, with the other bits 0, and removes it. While bit 13 is 0, incoming frames are not stored.
- R5: A received parity bit that disagrees with the configured parity sets status bit 16. A first stop bit sampled as 0 sets status bit 17. The character is stored in both cases.
- R6: Each queue holds 64 characters. A write to a full transmit queue is dropped. A character received into a full receive queue is dropped. Either drop sets status bit 18.
- R7: The error flags are sticky until cleared. While control bit 24 is 1 they read 0 and cannot be set. Returning the bit to 0 leaves them clear until a new error.
- R8: While control bit 22 (transmit) or bit 23 (receive) is 1, that queue is held empty.
- R9: Status bit 20 shows the receive queue empty, bit 21 the transmit queue full, and bit 22 the transmit queue empty. Bit 25 is 1 while a frame is being shifted out. After reset the status reads only bits 20 and 22 set.
- R10: `irqRx` is 1 when control bit 27 is set and the receive count is at or above threshold bits 7:0. `irqTx` is 1 when control bit 28 is set and the transmit count is at or below threshold bits 15:8. `irq` is their OR.
- R11: A low pulse on `rxd` shorter than half a bit is not taken as a start bit. The start bit is checked 8 ticks after its falling edge, and every later bit is sampled 16 ticks after the previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte offset, word aligned |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| bitTick | input | 1 | 16x oversampling tick from the rate divider |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| baudCfg | output | 32 | Rate register contents for the divider |
| irqRx | output | 1 | Receive interrupt |
| irqTx | output | 1 | Transmit interrupt |
| irq | output | 1 | OR of both interrupts |

## Verification
The transmit line is looped back to the receiver. Frames are sent in four shapes: 8 bits with no parity, 7 bits with even parity, 5 bits with odd parity and two stops, and 6 bits with two stops. These tell apart errors in length decode, parity polarity and stop count, and an independent line decoder checks every bit against a queue of expected frames. Hand-built frames with a wrong parity bit or a zero stop bit separate the two error flags and exercise the hold-to-clear behaviour. Filling each queue with 64 and then 65 characters shows both the first-in order and the drop at the boundary. A three-cycle glitch on the input separates a true start bit from noise.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;
  // control bit positions
  localparam int CTL_TXEN   = 12;
  localparam int CTL_RXEN   = 13;
  localparam int CTL_STOP2  = 16;
  localparam int CTL_PARODD = 18;
  localparam int CTL_PAREN  = 19;
  localparam int CTL_LENLO  = 20;
  localparam int CTL_TXRST  = 22;
  localparam int CTL_RXRST  = 23;
  localparam int CTL_ERRCLR = 24;
  localparam int CTL_RXIE   = 27;
  localparam int CTL_TXIE   = 28;
  // status bit positions
  localparam int ST_PARERR  = 16;
  localparam int ST_FRMERR  = 17;
  localparam int ST_OVRERR  = 18;
  localparam int ST_RXEMPTY = 20;
  localparam int ST_TXFULL  = 21;
  localparam int ST_TXEMPTY = 22;
  localparam int ST_TXBUSY  = 25;

  typedef enum logic [2:0] {
    REG_TXDATA = 3'd0, REG_RXDATA = 3'd1, REG_CTRL = 3'd2,
    REG_STATUS = 3'd3, REG_THRESH = 3'd4, REG_BAUD = 3'd5
  } regIdx_t;

  typedef enum logic [2:0] {
    SH_IDLE, SH_START, SH_DATA, SH_PAR, SH_STOP
  } shState_t;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic       txPush;
    logic [7:0] txData;
    logic       rxPop;
    logic       txFlush;
    logic       rxFlush;
    logic       txEn;
    logic       rxEn;
    logic [1:0] lenSel;
    logic       parEn;
    logic       parOdd;
    logic       twoStop;
  } dpCtrl_t;

  // events from datapath to control
  typedef struct packed {
    logic parErr;
    logic frmErr;
    logic rxDrop;
    logic txBusy;
  } dpEvt_t;
endpackage

// File: rtl/uart_mmio_fifo.sv
module uart_mmio_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic             doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full && !flush;
  assign doPop  = pop && !empty && !flush;
  assign dout   = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
endmodule

// File: rtl/uart_mmio_dp.sv
module uart_mmio_dp
  import uart_mmio_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitTick,
  input  dpCtrl_t       ctl,
  input  logic          rxd,
  output logic          txd,
  output dpEvt_t        evt,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount,
  output logic [7:0]    rxHead
);
  logic [3:0] nBits;
  logic [2:0] lastIdx;
  logic [7:0] dataMask;
  assign nBits    = 4'd8 - {2'b00, ctl.lenSel};
  assign lastIdx  = 3'(nBits - 4'd1);
  assign dataMask = 8'hFF >> ctl.lenSel;

  // ---------------- transmit ----------------
  shState_t   txState;
  logic [7:0] txShift;
  logic [3:0] txTick;
  logic [2:0] txIdx;
  logic       txPar, txStop2;
  logic [7:0] txFifoOut;
  logic       txEmpty, txFull, txStart;

  assign txStart = (txState == SH_IDLE) && ctl.txEn && !txEmpty && !ctl.txFlush;

  uart_mmio_fifo #(.WIDTH(8), .DEPTH(DEPTH), .CW(CW)) uTxFifo (
    .clk(clk), .rstN(rstN), .flush(ctl.txFlush),
    .push(ctl.txPush), .din(ctl.txData), .pop(txStart),
    .dout(txFifoOut), .count(txCount), .full(txFull), .empty(txEmpty)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= SH_IDLE;
      txShift <= '0;
      txTick  <= '0;
      txIdx   <= '0;
      txPar   <= 1'b0;
      txStop2 <= 1'b0;
      txd     <= 1'b1;
    end else if (txState == SH_IDLE) begin
      if (txStart) begin
        txState <= SH_START;
        txShift <= txFifoOut;
        txPar   <= (^(txFifoOut & dataMask)) ^ ctl.parOdd;
        txTick  <= '0;
        txd     <= 1'b0;
      end else begin
        txd <= 1'b1;
      end
    end else if (bitTick) begin
      txTick <= txTick + 4'd1;
      if (txTick == 4'd15) begin
        case (txState)
          SH_START: begin
            txState <= SH_DATA;
            txd     <= txShift[0];
            txIdx   <= '0;
          end
          SH_DATA: begin
            if (txIdx == lastIdx) begin
              if (ctl.parEn) begin
                txState <= SH_PAR;
                txd     <= txPar;
              end else begin
                txState <= SH_STOP;
                txd     <= 1'b1;
                txStop2 <= 1'b0;
              end
            end else begin
              txIdx   <= txIdx + 3'd1;
              txShift <= {1'b0, txShift[7:1]};
              txd     <= txShift[1];
            end
          end
          SH_PAR: begin
            txState <= SH_STOP;
            txd     <= 1'b1;
            txStop2 <= 1'b0;
          end
          SH_STOP: begin
            if (ctl.twoStop && !txStop2) txStop2 <= 1'b1;
            else                         txState <= SH_IDLE;
          end
          default: txState <= SH_IDLE;
        endcase
      end
    end
  end

  // ---------------- receive ----------------
  shState_t   rxState;
  logic       rxMeta, rxBit;
  logic [3:0] rxTick;
  logic [2:0] rxIdx;
  logic [7:0] rxShift, rxWord;
  logic       rxPush, rxPErr, rxFErr, rxFull, rxEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxBit  <= 1'b1;
    end else begin
      rxMeta <= rxd;
      rxBit  <= rxMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= SH_IDLE;
      rxTick  <= '0;
      rxIdx   <= '0;
      rxShift <= '0;
      rxWord  <= '0;
      rxPush  <= 1'b0;
      rxPErr  <= 1'b0;
      rxFErr  <= 1'b0;
    end else begin
      rxPush <= 1'b0;
      case (rxState)
        SH_IDLE: begin
          if (ctl.rxEn && !rxBit) begin
            rxState <= SH_START;
            rxTick  <= '0;
          end
        end
        SH_START: begin
          if (bitTick) begin
            rxTick <= rxTick + 4'd1;
            if (rxTick == 4'd7) begin
              if (!rxBit) begin
                rxState <= SH_DATA;
                rxTick  <= '0;
                rxIdx   <= '0;
                rxShift <= '0;
              end else begin
                rxState <= SH_IDLE;
              end
            end
          end
        end
        default: begin
          if (bitTick) begin
            rxTick <= rxTick + 4'd1;
            if (rxTick == 4'd15) begin
              case (rxState)
                SH_DATA: begin
                  rxShift[rxIdx] <= rxBit;
                  if (rxIdx == lastIdx) begin
                    rxState <= ctl.parEn ? SH_PAR : SH_STOP;
                    rxPErr  <= 1'b0;
                  end else begin
                    rxIdx <= rxIdx + 3'd1;
                  end
                end
                SH_PAR: begin
                  rxPErr  <= (rxBit != ((^rxShift) ^ ctl.parOdd));
                  rxState <= SH_STOP;
                end
                SH_STOP: begin
                  rxFErr  <= !rxBit;
                  rxWord  <= rxShift;
                  rxPush  <= 1'b1;
                  rxState <= SH_IDLE;
                end
                default: rxState <= SH_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end

  uart_mmio_fifo #(.WIDTH(8), .DEPTH(DEPTH), .CW(CW)) uRxFifo (
    .clk(clk), .rstN(rstN), .flush(ctl.rxFlush),
    .push(rxPush), .din(rxWord), .pop(ctl.rxPop),
    .dout(rxHead), .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  assign evt.parErr = rxPush && rxPErr;
  assign evt.frmErr = rxPush && rxFErr;
  assign evt.rxDrop = rxPush && rxFull;
  assign evt.txBusy = (txState != SH_IDLE);

  p_tx_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txState == SH_IDLE && !ctl.txEn) |=> (txState == SH_IDLE));
  p_rx_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxFull && !ctl.rxPop && !ctl.rxFlush) |=> (rxCount == $past(rxCount)));
  p_tx_idle_line_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txState == SH_IDLE && $past(txState) == SH_IDLE) |-> txd);
endmodule

// File: rtl/uart_mmio_ctl.sv
module uart_mmio_ctl
  import uart_mmio_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busSel,
  input  logic          busWrite,
  input  logic [4:0]    busAddr,
  input  logic [31:0]   busWdata,
  output logic [31:0]   busRdata,
  output dpCtrl_t       ctl,
  input  dpEvt_t        evt,
  input  logic [CW-1:0] txCount,
  input  logic [CW-1:0] rxCount,
  input  logic [7:0]    rxHead,
  output logic [31:0]   baudCfg,
  output logic          irqRx,
  output logic          irqTx
);
  logic [31:0] ctrlReg, baudReg;
  logic [15:0] thrReg;
  logic [2:0]  errFlags;   // 0 parity, 1 framing, 2 overflow
  logic [31:0] statusWord;
  logic        hit, wrHit, rdHit;
  logic [2:0]  regIdx;
  logic        txFull, txEmpty, rxEmpty, txOvr;

  assign regIdx  = busAddr[4:2];
  assign hit     = busSel && (busAddr[1:0] == 2'b00);
  assign wrHit   = hit && busWrite;
  assign rdHit   = hit && !busWrite;
  assign txFull  = (txCount == CW'(DEPTH));
  assign txEmpty = (txCount == '0);
  assign rxEmpty = (rxCount == '0);
  assign txOvr   = wrHit && (regIdx == REG_TXDATA) && txFull;

  always_comb begin
    ctl.txPush  = wrHit && (regIdx == REG_TXDATA) && !txFull;
    ctl.txData  = busWdata[7:0];
    ctl.rxPop   = rdHit && (regIdx == REG_RXDATA) && !rxEmpty;
    ctl.txFlush = ctrlReg[CTL_TXRST];
    ctl.rxFlush = ctrlReg[CTL_RXRST];
    ctl.txEn    = ctrlReg[CTL_TXEN];
    ctl.rxEn    = ctrlReg[CTL_RXEN];
    ctl.lenSel  = ctrlReg[CTL_LENLO+1:CTL_LENLO];
    ctl.parEn   = ctrlReg[CTL_PAREN];
    ctl.parOdd  = ctrlReg[CTL_PARODD];
    ctl.twoStop = (ctrlReg[CTL_STOP2+1:CTL_STOP2] == 2'b01);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      thrReg  <= '0;
      baudReg <= '0;
    end else if (wrHit) begin
      case (regIdx)
        REG_CTRL:   ctrlReg <= busWdata;
        REG_THRESH: thrReg  <= busWdata[15:0];
        REG_BAUD:   baudReg <= busWdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlags <= '0;
    end else if (ctrlReg[CTL_ERRCLR]) begin
      errFlags <= '0;
    end else begin
      errFlags <= errFlags | {txOvr || evt.rxDrop, evt.frmErr, evt.parErr};
    end
  end

  always_comb begin
    statusWord             = '0;
    statusWord[ST_PARERR]  = errFlags[0];
    statusWord[ST_FRMERR]  = errFlags[1];
    statusWord[ST_OVRERR]  = errFlags[2];
    statusWord[ST_RXEMPTY] = rxEmpty;
    statusWord[ST_TXFULL]  = txFull;
    statusWord[ST_TXEMPTY] = txEmpty;
    statusWord[ST_TXBUSY]  = evt.txBusy;
  end

  always_comb begin
    busRdata = '0;
    if (rdHit) begin
      case (regIdx)
        REG_RXDATA: busRdata = rxEmpty ? '0 : {24'd0, rxHead};
        REG_CTRL:   busRdata = ctrlReg;
        REG_STATUS: busRdata = statusWord;
        REG_THRESH: busRdata = {16'd0, thrReg};
        REG_BAUD:   busRdata = baudReg;
        default:    busRdata = '0;
      endcase
    end
  end

  assign baudCfg = baudReg;
  assign irqRx   = ctrlReg[CTL_RXIE] && (9'(rxCount) >= 9'(thrReg[7:0]));
  assign irqTx   = ctrlReg[CTL_TXIE] && (9'(txCount) <= 9'(thrReg[15:8]));

  p_errclr_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[CTL_ERRCLR] |=> (errFlags == '0));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[CTL_ERRCLR] |=> ((errFlags & $past(errFlags)) == $past(errFlags)));
  p_rx_irq_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == '0 && thrReg[7:0] != 8'd0) |-> !irqRx);
  p_tx_irq_full_r10: assert property (@(posedge clk) disable iff (!rstN)
    (txFull && 9'(thrReg[15:8]) < 9'(DEPTH)) |-> !irqTx);
endmodule

// File: rtl/uart_mmio_core.sv
module uart_mmio_core #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [4:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        bitTick,
  input  logic        rxd,
  output logic        txd,
  output logic [31:0] baudCfg,
  output logic        irqRx,
  output logic        irqTx,
  output logic        irq
);
  import uart_mmio_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);

  dpCtrl_t       ctl;
  dpEvt_t        evt;
  logic [CW-1:0] txCount, rxCount;
  logic [7:0]    rxHead;

  uart_mmio_ctl #(.DEPTH(DEPTH), .CW(CW)) uCtl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .ctl(ctl), .evt(evt), .txCount(txCount), .rxCount(rxCount),
    .rxHead(rxHead), .baudCfg(baudCfg), .irqRx(irqRx), .irqTx(irqTx)
  );

  uart_mmio_dp #(.DEPTH(DEPTH), .CW(CW)) uDp (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .ctl(ctl), .rxd(rxd),
    .txd(txd), .evt(evt), .txCount(txCount), .rxCount(rxCount),
    .rxHead(rxHead)
  );

  assign irq = irqRx || irqTx;
endmodule

// File: tb/tb_uart_mmio_core.sv
`timescale 1ns/1ps
module tb_uart_mmio_core;
  localparam logic [4:0] A_TX = 5'h00, A_RX = 5'h04, A_CTRL = 5'h08,
                         A_STAT = 5'h0C, A_THR = 5'h10, A_BAUD = 5'h14;
  localparam int B_TXEN = 12, B_RXEN = 13, B_TWOWIRE = 15, B_STOP = 16,
                 B_PODD = 18, B_PEN = 19, B_LEN = 20, B_TXRST = 22,
                 B_RXRST = 23, B_CLR = 24, B_RXIE = 27, B_TXIE = 28;
  localparam int S_PAR = 16, S_FRM = 17, S_OVR = 18, S_RXE = 20,
                 S_TXF = 21, S_TXE = 22, S_BUSY = 25;

  logic clk = 0, rstN = 0;
  logic busSel = 0, busWrite = 0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata, baudCfg;
  logic bitTick = 1, rxdDrv = 1, loopBack = 0, txd, rxd, irqRx, irqTx, irq;
  assign rxd = loopBack ? txd : rxdDrv;

  uart_mmio_core dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .bitTick(bitTick), .rxd(rxd), .txd(txd), .baudCfg(baudCfg),
    .irqRx(irqRx), .irqTx(irqTx), .irq(irq)
  );

  always #2 clk = ~clk;  // 250 MHz

  int nChecks = 0, nErr = 0, monFrames = 0;
  bit doneFlag = 0;
  logic [31:0] ctrlVal = '0;
  logic [1:0] curLen = 0;
  logic curPen = 0, curPodd = 0, curTwo = 0;
  logic [12:0] expQ[$];  // {two, podd, pen, len[1:0], data[7:0]}

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic setCtrl(input logic [31:0] v);
    ctrlVal = v;
    curLen  = v[B_LEN+1:B_LEN];
    curPen  = v[B_PEN];
    curPodd = v[B_PODD];
    curTwo  = (v[B_STOP+1:B_STOP] == 2'b01);
    busWr(A_CTRL, v);
  endtask

  task automatic clrErr();
    busWr(A_CTRL, ctrlVal | (32'd1 << B_CLR));
    busWr(A_CTRL, ctrlVal);
  endtask

  // driver: queue the expected frame, then write the character
  task automatic txPut(input logic [7:0] d);
    expQ.push_back({curTwo, curPodd, curPen, curLen, d});
    busWr(A_TX, {24'd0, d});
  endtask

  task automatic txDrain();
    wait (expQ.size() == 0);
    repeat (40) @(negedge clk);
  endtask

  task automatic rxSend(input logic [7:0] d, input int nb, input logic pen,
                        input logic podd, input logic badPar, input logic badStop);
    logic [7:0] m;
    m = d & (8'hFF >> (8 - nb));
    @(negedge clk); rxdDrv = 0; repeat (16) @(negedge clk);
    for (int i = 0; i < nb; i++) begin rxdDrv = m[i]; repeat (16) @(negedge clk); end
    if (pen) begin rxdDrv = (^m) ^ podd ^ badPar; repeat (16) @(negedge clk); end
    rxdDrv = !badStop; repeat (16) @(negedge clk);
    rxdDrv = 1; repeat (20) @(negedge clk);
  endtask

  // monitor: decode txd on its own and compare with the queue (R2)
  initial begin
    forever begin
      @(negedge clk);
      if (doneFlag) break;
      if (txd === 1'b0) begin
        if (expQ.size() == 0) begin
          nChecks++; nErr++;
          $display("FAIL R3 unexpected frame on txd actual=start expected=idle");
          repeat (250) @(negedge clk);
        end else begin
          logic [12:0] e;
          int nb;
          logic [7:0] got, m;
          logic st, pb, s1, s2, epb;
          e = expQ[0];
          nb = 8 - int'(e[9:8]);
          got = '0; pb = 0; s2 = 0;
          repeat (8) @(negedge clk);
          st = txd;
          for (int i = 0; i < nb; i++) begin repeat (16) @(negedge clk); got[i] = txd; end
          if (e[10]) begin repeat (16) @(negedge clk); pb = txd; end
          repeat (16) @(negedge clk); s1 = txd;
          if (e[12]) begin repeat (16) @(negedge clk); s2 = txd; end
          m = e[7:0] & (8'hFF >> e[9:8]);
          epb = e[10] ? ((^m) ^ e[11]) : 1'b0;
          check("R2 tx frame {stop2,stop1,par,data,start}",
                {20'd0, s2, s1, pb, got, st},
                {20'd0, e[12], 1'b1, epb, m, 1'b0});
          void'(expQ.pop_front());
          monFrames++;
        end
      end
    end
  end

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] r;
    int f0;
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);

    // reset state
    busRd(A_STAT, r); check("R9 reset status", r, (32'd1 << S_RXE) | (32'd1 << S_TXE));
    busRd(A_CTRL, r); check("R1 reset control", r, 32'd0);
    check("R10 reset irq", {29'd0, irqRx, irqTx, irq}, 32'd0);

    // R1 readback
    busWr(A_THR, 32'hFFFF_0A05);
    busRd(A_THR, r); check("R1 threshold readback", r, 32'h0000_0A05);
    busWr(A_BAUD, 32'h8012_3456);
    busRd(A_BAUD, r); check("R1 rate readback", r, 32'h8012_3456);
    check("R1 rate port", baudCfg, 32'h8012_3456);

    // R2/R4: loopback, 8 bits no parity one stop
    loopBack = 1;
    setCtrl((32'd1 << B_TXEN) | (32'd1 << B_RXEN) | (32'd1 << B_TWOWIRE));
    txPut(8'hA5); txPut(8'h3C);
    txDrain();
    busRd(A_RX, r); check("R4 rx 8N1 first", r, 32'h0000_00A5);
    busRd(A_RX, r); check("R4 rx 8N1 second", r, 32'h0000_003C);

    // R9 busy while shifting
    txPut(8'h55);
    repeat (40) @(negedge clk);
    busRd(A_STAT, r);
    check("R9 busy and tx empty mid frame", r & ((32'd1 << S_BUSY) | (32'd1 << S_TXE)),
          (32'd1 << S_BUSY) | (32'd1 << S_TXE));
    txDrain();
    busRd(A_STAT, r); check("R9 busy clears after frame", r[S_BUSY], 32'd0);
    busRd(A_RX, r); check("R4 rx after busy test", r, 32'h55);

    // 7 bits even parity
    setCtrl((32'd1 << B_TXEN) | (32'd1 << B_RXEN) | (32'd1 << B_PEN) | (32'd1 << B_LEN));
    txPut(8'hFF); txDrain();
    busRd(A_RX, r); check("R4 rx 7E1", r, 32'h7F);
    // 5 bits odd parity two stops
    setCtrl((32'd1 << B_TXEN) | (32'd1 << B_RXEN) | (32'd1 << B_PEN) | (32'd1 << B_PODD) |
            (32'd3 << B_LEN) | (32'd1 << B_STOP));
    txPut(8'hF3); txDrain();
    busRd(A_RX, r); check("R4 rx 5O2", r, 32'h13);
    // 6 bits no parity two stops
    setCtrl((32'd1 << B_TXEN) | (32'd1 << B_RXEN) | (32'd2 << B_LEN) | (32'd1 << B_STOP));
    txPut(8'h2A); txDrain();
    busRd(A_RX, r); check("R4 rx 6N2", r, 32'h2A);
    busRd(A_STAT, r); check("R5 no error after clean frames", r & 32'h7_0000, 32'd0);

    // R3 transmit gated by enable
    setCtrl((32'd1 << B_RXEN));
    f0 = monFrames;
    txPut(8'h81);
    repeat (300) @(negedge clk);
    check("R3 no frame while disabled", monFrames - f0, 32'd0);
    check("R3 txd idle while disabled", {31'd0, txd}, 32'd1);
    busRd(A_STAT, r); check("R3 char waits in queue", r[S_TXE], 32'd0);
    setCtrl((32'd1 << B_RXEN) | (32'd1 << B_TXEN));
    txDrain();
    check("R3 frame after enable", monFrames - f0, 32'd1);
    busRd(A_RX, r); check("R4 rx after enable", r, 32'h81);

    // R5 errors with hand-built frames, 8 bits even parity
    loopBack = 0;
    setCtrl((32'd1 << B_RXEN) | (32'd1 << B_PEN));
    rxSend(8'h12, 8, 1, 0, 1, 0);
    busRd(A_STAT, r); check("R5 parity error flag", r & 32'h7_0000, 32'd1 << S_PAR);
    clrErr();
    rxSend(8'h34, 8, 1, 0, 0, 1);
    busRd(A_STAT, r); check("R5 framing error flag", r & 32'h7_0000, 32'd1 << S_FRM);
    busRd(A_RX, r); check("R5 char kept on parity error", r, 32'h12);
    busRd(A_RX, r); check("R5 char kept on framing error", r, 32'h34);

    // R7 hold-to-clear
    busWr(A_CTRL, ctrlVal | (32'd1 << B_CLR));
    busRd(A_STAT, r); check("R7 flags cleared while held", r & 32'h7_0000, 32'd0);
    rxSend(8'h56, 8, 1, 0, 1, 0);
    busRd(A_STAT, r); check("R7 no set while held", r & 32'h7_0000, 32'd0);
    busWr(A_CTRL, ctrlVal);
    busRd(A_STAT, r); check("R7 still clear after release", r & 32'h7_0000, 32'd0);
    rxSend(8'h57, 8, 1, 0, 1, 0);
    rxSend(8'h58, 8, 1, 0, 0, 0);
    busRd(A_STAT, r); check("R7 sticky after good frame", r & 32'h7_0000, 32'd1 << S_PAR);
    busWr(A_CTRL, ctrlVal | (32'd1 << B_RXRST)); busWr(A_CTRL, ctrlVal);
    clrErr();

    // R6 transmit overflow, R8 transmit flush
    setCtrl(32'd0);
    for (int i = 0; i < 64; i++) busWr(A_TX, i);
    busRd(A_STAT, r);
    check("R6 64 writes fill without overflow", r & ((32'd1 << S_TXF) | (32'd1 << S_OVR)),
          32'd1 << S_TXF);
    busWr(A_TX, 32'hEE);
    busRd(A_STAT, r); check("R6 tx overflow flag", r[S_OVR], 32'd1);
    busWr(A_CTRL, 32'd1 << B_TXRST);
    busRd(A_STAT, r);
    check("R8 tx queue held empty", r & ((32'd1 << S_TXF) | (32'd1 << S_TXE)), 32'd1 << S_TXE);
    busWr(A_TX, 32'h11);
    busRd(A_STAT, r); check("R8 write ignored during flush", r[S_TXE], 32'd1);
    setCtrl(32'd0); clrErr();

    // R6 receive overflow
    setCtrl(32'd1 << B_RXEN);
    for (int i = 0; i < 64; i++) rxSend(8'(i), 8, 0, 0, 0, 0);
    busRd(A_STAT, r); check("R6 64 received no overflow", r[S_OVR], 32'd0);
    rxSend(8'hC3, 8, 0, 0, 0, 0);
    busRd(A_STAT, r); check("R6 rx overflow flag", r[S_OVR], 32'd1);
    busRd(A_RX, r); check("R6 oldest kept", r, 32'h00);
    busRd(A_RX, r); check("R6 order kept", r, 32'h01);
    busWr(A_CTRL, ctrlVal | (32'd1 << B_RXRST));
    busRd(A_STAT, r); check("R8 rx queue held empty", r[S_RXE], 32'd1);
    busRd(A_RX, r); check("R8 empty read returns zero", r, 32'd0);
    busWr(A_CTRL, ctrlVal); clrErr();

    // R10 interrupts
    busWr(A_THR, 32'h0000_0102);
    setCtrl((32'd1 << B_RXEN) | (32'd1 << B_RXIE) | (32'd1 << B_TXIE));
    check("R10 tx irq at empty", {29'd0, irqRx, irqTx, irq}, 32'b011);
    busWr(A_TX, 32'h01); busWr(A_TX, 32'h02);
    @(negedge clk);
    check("R10 tx irq off above threshold", {29'd0, irqRx, irqTx, irq}, 32'b000);
    rxSend(8'h61, 8, 0, 0, 0, 0);
    check("R10 rx irq below threshold", {31'd0, irqRx}, 32'd0);
    rxSend(8'h62, 8, 0, 0, 0, 0);
    check("R10 rx irq at threshold", {29'd0, irqRx, irqTx, irq}, 32'b101);
    busWr(A_CTRL, ctrlVal & ~(32'd1 << B_RXIE));
    check("R10 rx irq masked", {31'd0, irqRx}, 32'd0);
    busWr(A_CTRL, ctrlVal | (32'd1 << B_RXRST) | (32'd1 << B_TXRST));
    setCtrl(32'd1 << B_RXEN);

    // R11 short glitch is not a start bit
    @(negedge clk); rxdDrv = 0; repeat (3) @(negedge clk); rxdDrv = 1;
    repeat (200) @(negedge clk);
    busRd(A_STAT, r); check("R11 glitch ignored", r[S_RXE], 32'd1);
    rxSend(8'h9C, 8, 0, 0, 0, 0);
    busRd(A_RX, r); check("R11 real frame after glitch", r, 32'h9C);

    // R4 receiver disabled
    setCtrl(32'd0);
    rxSend(8'h77, 8, 0, 0, 0, 0);
    busRd(A_STAT, r); check("R4 disabled receiver stores nothing", r[S_RXE], 32'd1);

    finishRun();
  end
endmodule